// File: doc/BRIEF.md
# Packed Allocation-Tag Writer

This block updates a byte-wide tag memory in which every byte carries the 4-bit allocation tags of two neighbouring 16-byte granules. A request names an operation, a byte address, a granule count (used by one operation only) and a tag. Four operations exist: a store to one granule, a store to two adjacent granules, a fill of a naturally aligned block, and a set over an arbitrary granule-aligned run of granules.

Every operation reduces to a start granule and a granule count. That span is then split three ways: an optional leading odd granule, a run of whole bytes written with the tag replicated into both nibbles, and an optional trailing even granule. A lone nibble is written by reading the byte and writing it back with the other nibble kept. Whole bytes need no read. The memory port is a plain synchronous byte port with one cycle of read latency. A `busy` flag holds off new requests, and a one-cycle `done` pulse closes each operation.

Top module: `tag_pack_writer`

## Requirements
- R1: The tag of byte address A is held in tag byte A >> 5. Nibble [3:0] serves granules with address bit 4 clear, and nibble [7:4] serves granules with address bit 4 set.
- R2: Operation codes 0 (one granule), 1 (two granules) and 3 (span set) need req_addr[3:0] == 0. A misaligned request makes no memory access and never raises busy. It produces `done` and `fault` together, one cycle after it is accepted.
- R3: A one-granule store (code 0) changes only the selected nibble. The other nibble of that byte and all other bytes keep their values.
- R4: A two-granule store (code 1) at a 32-byte-aligned address writes one whole byte equal to tag * 0x11, with no read, and takes one busy cycle.
- R5: A two-granule store at an odd granule writes the high nibble of byte k and the low nibble of byte k+1. The other nibbles of both bytes are kept.
- R6: A block fill (code 2) rounds the address down to a multiple of 2^BLOCK_LOG2 bytes and writes tag * 0x11 into every tag byte of that block. Its low address bits never cause a fault.
- R7: A span set (code 3) of N granules from an odd granule writes the high nibble of the first byte, then floor((N-1)/2) whole replicated bytes, then the low nibble of the next byte if one granule is left. With N = 0 it writes nothing.
- R8: A partial nibble costs two busy cycles (read, then write) and a whole byte costs one. busy stays high for exactly 2*head + full + 2*tail cycles after the accepting edge, and done pulses in the cycle that follows with busy low.
- R9: A request presented while busy is high is ignored. The memory afterwards shows only the effect of the operation in progress.
- R10: While reset is held and right after it, busy, done, fault, mem_rd_en and mem_wr_en are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe, taken when busy is low |
| req_op | input | 2 | 0 one granule, 1 two granules, 2 block fill, 3 span set |
| req_addr | input | ADDR_W (12) | Byte address of the first granule |
| req_count | input | ADDR_W-3 (9) | Granule count for span set |
| req_tag | input | 4 | Tag value to store |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle end-of-operation pulse |
| fault | output | 1 | Alignment fault, valid with done |
| mem_rd_en | output | 1 | Tag memory read strobe |
| mem_wr_en | output | 1 | Tag memory write strobe |
| mem_addr | output | ADDR_W-5 (7) | Tag byte address |
| mem_wdata | output | 8 | Tag byte write data |
| mem_rdata | input | 8 | Read data, valid the cycle after mem_rd_en |

## Verification
A wrong nibble select or a stale merge value shows up at the ports as a byte in which the untouched neighbour tag has changed. It can be seen in the tag memory as soon as the operation's done pulse arrives. A miscounted head, body or tail changes how long busy stays high, so it is caught in the first cycle where busy differs from the cycle count the bench predicts. A wrong address step shows up as the tag landing in a neighbouring byte of the memory. The bench compares every byte of the memory against a shadow nibble array after each operation, including spans that start or end on an odd granule and stores into the top byte.

// File: rtl/tag_pack_pkg.sv
package tag_pack_pkg;
  typedef enum logic [1:0] {
    OP_ONE   = 2'd0,
    OP_TWO   = 2'd1,
    OP_BLOCK = 2'd2,
    OP_SPAN  = 2'd3
  } tag_op_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_HEAD_RD,
    ST_HEAD_WR,
    ST_FILL,
    ST_TAIL_RD,
    ST_TAIL_WR
  } seq_state_e;

  typedef enum logic [1:0] {
    MRG_LOW  = 2'd0,
    MRG_HIGH = 2'd1,
    MRG_FULL = 2'd2
  } merge_mode_e;
endpackage

// File: rtl/tag_span_plan.sv
module tag_span_plan
  import tag_pack_pkg::*;
#(
  parameter int ADDR_W     = 12,
  parameter int BLOCK_LOG2 = 7
) (
  input  logic [1:0]        op,
  input  logic [ADDR_W-1:0] addr,
  input  logic [ADDR_W-4:0] count,
  output logic              misaligned,
  output logic [ADDR_W-6:0] start_byte,
  output logic              head,
  output logic [ADDR_W-4:0] full_cnt,
  output logic              tail
);
  localparam int G_W    = ADDR_W - 4;
  localparam int CNT_W  = G_W + 1;
  localparam int BLK_GR = 1 << (BLOCK_LOG2 - 4);
  localparam logic [G_W-1:0] BLK_MASK = G_W'(BLK_GR - 1);

  logic [G_W-1:0]   gran;
  logic [CNT_W-1:0] n_gran;
  logic [CNT_W-1:0] rem;

  always_comb begin
    gran       = addr[ADDR_W-1:4];
    n_gran     = count;
    misaligned = 1'b0;
    unique case (tag_op_e'(op))
      OP_ONE: begin
        n_gran     = CNT_W'(1);
        misaligned = |addr[3:0];
      end
      OP_TWO: begin
        n_gran     = CNT_W'(2);
        misaligned = |addr[3:0];
      end
      OP_BLOCK: begin
        gran   = addr[ADDR_W-1:4] & ~BLK_MASK;
        n_gran = CNT_W'(BLK_GR);
      end
      default: begin
        n_gran     = count;
        misaligned = |addr[3:0];
      end
    endcase
    head       = gran[0] && (n_gran != '0);
    rem        = n_gran - CNT_W'(head);
    full_cnt   = rem >> 1;
    tail       = rem[0];
    start_byte = gran[G_W-1:1];
  end
endmodule

// File: rtl/tag_nibble_merge.sv
module tag_nibble_merge
  import tag_pack_pkg::*;
(
  input  logic [1:0] mode,
  input  logic [7:0] old_byte,
  input  logic [3:0] tag,
  output logic [7:0] new_byte
);
  always_comb begin
    unique case (merge_mode_e'(mode))
      MRG_LOW:  new_byte = {old_byte[7:4], tag};
      MRG_HIGH: new_byte = {tag, old_byte[3:0]};
      default:  new_byte = {tag, tag};
    endcase
  end
endmodule

// File: rtl/tag_pack_writer.sv
module tag_pack_writer
  import tag_pack_pkg::*;
#(
  parameter int ADDR_W     = 12,
  parameter int BLOCK_LOG2 = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [1:0]        req_op,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [ADDR_W-4:0] req_count,
  input  logic [3:0]        req_tag,
  output logic              busy,
  output logic              done,
  output logic              fault,
  output logic              mem_rd_en,
  output logic              mem_wr_en,
  output logic [ADDR_W-6:0] mem_addr,
  output logic [7:0]        mem_wdata,
  input  logic [7:0]        mem_rdata
);
  localparam int TB_W  = ADDR_W - 5;
  localparam int CNT_W = ADDR_W - 3;

  logic              p_mis, p_head, p_tail;
  logic [TB_W-1:0]   p_byte;
  logic [CNT_W-1:0]  p_full;

  seq_state_e        state_q;
  logic [TB_W-1:0]   byte_q;
  logic [CNT_W-1:0]  full_q;
  logic              tail_q;
  logic [3:0]        tag_q;
  logic              done_q, fault_q;
  logic [1:0]        mrg_mode;
  logic              accept;

  tag_span_plan #(.ADDR_W(ADDR_W), .BLOCK_LOG2(BLOCK_LOG2)) plan_i (
    .op(req_op), .addr(req_addr), .count(req_count),
    .misaligned(p_mis), .start_byte(p_byte), .head(p_head),
    .full_cnt(p_full), .tail(p_tail)
  );

  always_comb begin
    if (state_q == ST_HEAD_WR)      mrg_mode = MRG_HIGH;
    else if (state_q == ST_TAIL_WR) mrg_mode = MRG_LOW;
    else                            mrg_mode = MRG_FULL;
  end

  tag_nibble_merge merge_i (
    .mode(mrg_mode), .old_byte(mem_rdata), .tag(tag_q), .new_byte(mem_wdata)
  );

  assign accept    = req_valid && (state_q == ST_IDLE);
  assign busy      = (state_q != ST_IDLE);
  assign done      = done_q;
  assign fault     = fault_q;
  assign mem_addr  = byte_q;
  assign mem_rd_en = (state_q == ST_HEAD_RD) || (state_q == ST_TAIL_RD);
  assign mem_wr_en = (state_q == ST_HEAD_WR) || (state_q == ST_FILL) ||
                     (state_q == ST_TAIL_WR);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      byte_q  <= '0;
      full_q  <= '0;
      tail_q  <= 1'b0;
      tag_q   <= '0;
      done_q  <= 1'b0;
      fault_q <= 1'b0;
    end else begin
      done_q  <= 1'b0;
      fault_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (accept) begin
            tag_q  <= req_tag;
            byte_q <= p_byte;
            full_q <= p_full;
            tail_q <= p_tail;
            if (p_mis) begin
              done_q  <= 1'b1;
              fault_q <= 1'b1;
            end else if (p_head)        state_q <= ST_HEAD_RD;
            else if (p_full != '0)      state_q <= ST_FILL;
            else if (p_tail)            state_q <= ST_TAIL_RD;
            else                        done_q  <= 1'b1;
          end
        end
        ST_HEAD_RD: state_q <= ST_HEAD_WR;
        ST_HEAD_WR: begin
          byte_q <= byte_q + 1'b1;
          if (full_q != '0) state_q <= ST_FILL;
          else if (tail_q)  state_q <= ST_TAIL_RD;
          else begin
            state_q <= ST_IDLE;
            done_q  <= 1'b1;
          end
        end
        ST_FILL: begin
          byte_q <= byte_q + 1'b1;
          full_q <= full_q - 1'b1;
          if (full_q == CNT_W'(1)) begin
            if (tail_q) state_q <= ST_TAIL_RD;
            else begin
              state_q <= ST_IDLE;
              done_q  <= 1'b1;
            end
          end
        end
        ST_TAIL_RD: state_q <= ST_TAIL_WR;
        ST_TAIL_WR: begin
          state_q <= ST_IDLE;
          done_q  <= 1'b1;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  AST_NO_RD_WR: assert property (@(posedge clk) disable iff (rst)
    !(mem_rd_en && mem_wr_en)); // R8
  AST_WR_FOLLOWS_RD: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_HEAD_WR || state_q == ST_TAIL_WR) |->
      ($past(mem_rd_en) && $past(mem_addr) == mem_addr)); // R8
  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (rst)
    (mem_wr_en && $past(mem_wr_en)) |->
      ((mem_addr - $past(mem_addr)) == TB_W'(1))); // R7
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy); // R8
  AST_FAULT_DONE: assert property (@(posedge clk) disable iff (rst)
    fault |-> (done && !mem_wr_en)); // R2
  AST_BUSY_FROM_ACCEPT: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(req_valid)); // R9
endmodule

// File: tb/tag_pack_writer_tb_top.sv
module tag_pack_writer_tb_top;
  localparam int ADDR_W     = 12;
  localparam int BLOCK_LOG2 = 7;
  localparam int NBYTE      = 1 << (ADDR_W - 5);
  localparam int NGRAN      = 1 << (ADDR_W - 4);

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              req_valid = 1'b0;
  logic [1:0]        req_op = '0;
  logic [ADDR_W-1:0] req_addr = '0;
  logic [ADDR_W-4:0] req_count = '0;
  logic [3:0]        req_tag = '0;
  logic              busy, done, fault, mem_rd_en, mem_wr_en;
  logic [ADDR_W-6:0] mem_addr;
  logic [7:0]        mem_wdata;
  logic [7:0]        mem_rdata = '0;

  logic [7:0] mem [NBYTE];
  logic [3:0] shadow [NGRAN];
  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  tag_pack_writer #(.ADDR_W(ADDR_W), .BLOCK_LOG2(BLOCK_LOG2)) dut_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_op(req_op),
    .req_addr(req_addr), .req_count(req_count), .req_tag(req_tag),
    .busy(busy), .done(done), .fault(fault), .mem_rd_en(mem_rd_en),
    .mem_wr_en(mem_wr_en), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata)
  );

  always @(posedge clk) begin
    if (mem_wr_en) mem[mem_addr] <= mem_wdata;
    if (mem_rd_en) mem_rdata <= mem[mem_addr];
  end

  task automatic check(input string req, input string what, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic check_mem(input string req);
    for (int b = 0; b < NBYTE; b++)
      check(req, $sformatf("tag byte %0d", b), int'(mem[b]),
            int'({shadow[2*b+1], shadow[2*b]}));
  endtask

  // junk: keep a different request on the inputs while busy (R9)
  task automatic do_op(input string req, input int op, input int addr,
                       input int cnt, input int tag, input bit junk);
    int g, n, hd, rem, lat;
    bit mis;
    mis = (op != 2) && ((addr & 15) != 0);
    g = addr >> 4;
    n = cnt;
    if (op == 0) n = 1;
    if (op == 1) n = 2;
    if (op == 2) begin
      g = (addr >> BLOCK_LOG2) << (BLOCK_LOG2 - 4);
      n = 1 << (BLOCK_LOG2 - 4);
    end
    hd  = ((g & 1) != 0 && n > 0) ? 1 : 0;
    rem = n - hd;
    lat = mis ? 0 : 2*hd + rem/2 + 2*(rem % 2);
    @(negedge clk);
    req_valid = 1'b1;
    req_op    = 2'(op);
    req_addr  = ADDR_W'(addr);
    req_count = (ADDR_W-3)'(cnt);
    req_tag   = 4'(tag);
    @(posedge clk);
    @(negedge clk);
    if (junk) begin
      req_op = 2'd3; req_addr = '0; req_count = (ADDR_W-3)'(NGRAN); req_tag = 4'hF;
    end else req_valid = 1'b0;
    for (int k = 0; k < lat; k++) begin
      check(req, "busy during op", int'(busy), 1);
      check(req, "done during op", int'(done), 0);
      @(negedge clk);
    end
    check(req, "done pulse", int'(done), 1);
    check(req, "busy at done", int'(busy), 0);
    check(req, "fault at done", int'(fault), int'(mis));
    req_valid = 1'b0;
    if (!mis)
      for (int i = 0; i < n; i++) shadow[(g + i) % NGRAN] = 4'(tag);
    check_mem(req);
  endtask

  initial begin
    for (int i = 0; i < NBYTE; i++) mem[i] = 8'h00;
    for (int i = 0; i < NGRAN; i++) shadow[i] = 4'h0;
    repeat (3) @(negedge clk);
    // R10: reset state
    check("R10", "busy in reset", int'(busy), 0);
    check("R10", "done in reset", int'(done), 0);
    check("R10", "rd in reset", int'(mem_rd_en), 0);
    check("R10", "wr in reset", int'(mem_wr_en), 0);
    rst = 1'b0;
    @(negedge clk);
    check("R10", "busy after reset", int'(busy), 0);
    check("R10", "fault after reset", int'(fault), 0);
    check("R10", "wr after reset", int'(mem_wr_en), 0);

    do_op("R7", 3, 'h000, NGRAN, 5, 0);     // whole memory, even start
    do_op("R1", 0, 'h040, 0, 'hA, 0);       // even granule, low nibble
    do_op("R3", 0, 'h050, 0, 'h3, 0);       // odd granule, high nibble
    do_op("R3", 0, 'hFF0, 0, 'h6, 0);       // top granule
    do_op("R2", 0, 'h048, 0, 'h9, 0);       // misaligned single
    do_op("R4", 1, 'h100, 0, 'h7, 0);       // aligned pair
    do_op("R5", 1, 'h130, 0, 'h9, 0);       // odd pair straddles bytes
    do_op("R2", 1, 'h134, 0, 'h1, 0);       // misaligned pair
    do_op("R6", 2, 'h2A7, 0, 'hC, 0);       // rounds down to 0x280
    do_op("R6", 2, 'h000, 0, 'h2, 0);
    do_op("R7", 3, 'h310, 6, 'hB, 0);       // head + 2 full + tail
    do_op("R7", 3, 'h400, 5, 'hD, 0);       // even start, tail
    do_op("R7", 3, 'h530, 1, 'h4, 0);       // head only
    do_op("R7", 3, 'h550, 2, 'hE, 0);       // head + tail
    do_op("R7", 3, 'h600, 0, 'h8, 0);       // empty span
    do_op("R2", 3, 'h608, 3, 'h8, 0);       // misaligned span
    do_op("R9", 3, 'h710, 9, 'h1, 1);       // junk held while busy
    do_op("R8", 0, 'h720, 0, 'hF, 1);
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule